// File: doc/BRIEF.md
# Half-Width Sequenced Vector ALU

This block runs packed integer operations on 128-bit vectors. It supports add and subtract on 32-bit lanes, add and subtract on 64-bit lanes, and bitwise AND, OR and XOR. An operation enters through a valid/ready port as an opcode plus two 128-bit operands. The 128-bit result leaves through a second valid/ready port.

By default the block has only a 64-bit execution unit. Each accepted vector operation therefore becomes two half-operations that follow each other through that one unit. The low 64 bits are computed in the cycle the operation is accepted, and that partial result is kept in a register. The high 64 bits are computed in the next cycle, and the two halves are joined into the output register. While the high half is in progress, the input port shows not-ready.

A parameter builds the other variant, a single 128-bit execution unit. That variant finishes each operation in one pass and can accept an operation every cycle. It is used to compare the two variants in area and throughput.

Top module: `vec_seq_alu`

## Requirements
- R1: The opcode is 3 bits: 0 = add 32-bit lanes, 1 = sub 32-bit lanes, 2 = add 64-bit lanes, 3 = sub 64-bit lanes, 4 = AND, 5 = OR, 6 = XOR. For opcode 0, each 32-bit lane i of the result (bits 32i+31..32i) is the sum of the matching operand lanes modulo 2^32.
- R2: For opcode 1, each 32-bit lane of the result equals lane of `in_a` minus lane of `in_b`, modulo 2^32.
- R3: For opcodes 2 and 3, each 64-bit lane (bits 63..0 and 127..64) is the sum, or the difference a minus b, modulo 2^64.
- R4: Opcodes 4, 5 and 6 give the bitwise AND, OR and XOR of the full 128-bit operands.
- R5: No carry or borrow crosses a lane boundary. This holds at bit 32 and bit 96 for 32-bit lanes, and at bit 64 in every mode, including between the two sequenced halves.
- R6: With `FULL_WIDTH` = 0, `out_valid` is low in the cycle after an operation is accepted and rises in the cycle after that, two cycles after acceptance.
- R7: With `FULL_WIDTH` = 0, `in_ready` is low in the cycle after each acceptance. Back-to-back operations are accepted at most once every two cycles.
- R8: With `FULL_WIDTH` = 1, `out_valid` is high in the cycle after acceptance. With `out_ready` held high, a new operation is accepted every cycle.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold their values and `in_ready` is low, so no new operation is taken.
- R10: During and right after synchronous reset, `out_valid` is low and `in_ready` is high.
- R11: Opcode 7 is reserved and gives an all-zero result. Its timing is the same as any other operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The block can take an operation this cycle |
| in_op | input | 3 | Operation code (see R1) |
| in_a | input | 128 | First operand vector |
| in_b | input | 128 | Second operand vector |
| out_valid | output | 1 | A result is held on `out_data` |
| out_ready | input | 1 | The consumer takes the result this cycle |
| out_data | output | 128 | Result vector |

## Verification
Both variants receive the same kinds of input. The first is hand-picked lane-boundary vectors: all-ones plus one, zero minus one, and values with the top bit of a lane set. These show whether a carry leaks across bit 32, bit 64 or bit 96, and whether the registered low half is joined with the wrong high half. The second is random operands under every opcode, including the reserved one. These are compared against a per-lane reference model and separate the lane-width decoding of the four arithmetic opcodes. The third is back-to-back streams, which measure the acceptance spacing of 2 cycles against 1. The last is a held output stall with a second operation waiting, which shows whether the block wrongly overwrites a result nobody has taken.

// File: rtl/vsa_pkg.sv
`timescale 1ns/1ps
package vsa_pkg;

    // Operation codes carried on the 3-bit opcode port
    typedef enum logic [2:0] {
        OP_ADD32 = 3'd0,
        OP_SUB32 = 3'd1,
        OP_ADD64 = 3'd2,
        OP_SUB64 = 3'd3,
        OP_AND   = 3'd4,
        OP_OR    = 3'd5,
        OP_XOR   = 3'd6,
        OP_RSVD  = 3'd7
    } alu_op_e;

    // Width of one execution segment; no lane is wider than this
    localparam int SEG_W  = 64;
    localparam int NARROW = 32;

    function automatic logic op_is_sub(alu_op_e op);
        return (op == OP_SUB32) || (op == OP_SUB64);
    endfunction

    function automatic logic op_is_narrow(alu_op_e op);
        return (op == OP_ADD32) || (op == OP_SUB32);
    endfunction

endpackage

// File: rtl/vsa_exec.sv
`timescale 1ns/1ps
// Combinational packed execution unit, W bits wide (a multiple of 64)
module vsa_exec
    import vsa_pkg::*;
#(
    parameter int W = 64
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y
);
    localparam int NSEG = W / SEG_W;

    logic sub;
    assign sub = op_is_sub(op);

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        logic [SEG_W-1:0]  x, yb, yi, s_wide, r;
        logic [NARROW-1:0] s_lo, s_hi;

        assign x  = a[g*SEG_W +: SEG_W];
        assign yb = b[g*SEG_W +: SEG_W];
        // subtraction is addition of the inverted operand plus one
        assign yi = sub ? ~yb : yb;

        // separate adders keep every carry inside its own lane
        assign s_wide = x + yi + {{(SEG_W-1){1'b0}}, sub};
        assign s_lo   = x[NARROW-1:0] + yi[NARROW-1:0] + {{(NARROW-1){1'b0}}, sub};
        assign s_hi   = x[SEG_W-1:NARROW] + yi[SEG_W-1:NARROW] + {{(NARROW-1){1'b0}}, sub};

        always_comb begin
            unique case (op)
                OP_ADD32, OP_SUB32: r = {s_hi, s_lo};
                OP_ADD64, OP_SUB64: r = s_wide;
                OP_AND:             r = x & yb;
                OP_OR:              r = x | yb;
                OP_XOR:             r = x ^ yb;
                default:            r = '0;
            endcase
        end

        assign y[g*SEG_W +: SEG_W] = r;
    end

endmodule

// File: rtl/vsa_seq_ctrl.sv
`timescale 1ns/1ps
// Handshake and half sequencing control
module vsa_seq_ctrl #(
    parameter bit FULL_WIDTH = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic accept,
    output logic phase_hi,
    output logic load_out,
    output logic out_valid
);
    logic slot_free;
    assign slot_free = !out_valid || out_ready;
    assign accept    = in_valid && in_ready;

    if (FULL_WIDTH) begin : g_full
        assign phase_hi = 1'b0;
        assign in_ready = slot_free;
        assign load_out = accept;
    end else begin : g_half
        logic phase_q;
        always_ff @(posedge clk) begin
            if (rst)           phase_q <= 1'b0;
            else if (phase_q)  phase_q <= 1'b0;
            else if (accept)   phase_q <= 1'b1;
        end
        assign phase_hi = phase_q;
        // second half in flight: hold off the next operation
        assign in_ready = !phase_q && slot_free;
        assign load_out = phase_q;
    end

    always_ff @(posedge clk) begin
        if (rst)            out_valid <= 1'b0;
        else if (load_out)  out_valid <= 1'b1;
        else if (out_ready) out_valid <= 1'b0;
    end

endmodule

// File: rtl/vec_seq_alu.sv
`timescale 1ns/1ps
module vec_seq_alu
    import vsa_pkg::*;
#(
    parameter bit FULL_WIDTH = 1'b0,
    parameter int VEC_W      = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [2:0]        in_op,
    input  logic [VEC_W-1:0]  in_a,
    input  logic [VEC_W-1:0]  in_b,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [VEC_W-1:0]  out_data
);
    localparam int HALF_W = VEC_W / 2;

    logic accept, phase_hi, load_out;
    logic [VEC_W-1:0] res_next;
    logic [VEC_W-1:0] out_q;

    vsa_seq_ctrl #(.FULL_WIDTH(FULL_WIDTH)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .accept    (accept),
        .phase_hi  (phase_hi),
        .load_out  (load_out),
        .out_valid (out_valid)
    );

    if (FULL_WIDTH) begin : g_full
        alu_op_e x_op;
        // the phase indicator stays low here; the unit sees the port directly
        assign x_op = phase_hi ? OP_RSVD : alu_op_e'(in_op);

        vsa_exec #(.W(VEC_W)) u_exec (
            .op (x_op),
            .a  (in_a),
            .b  (in_b),
            .y  (res_next)
        );
    end else begin : g_half
        typedef struct packed {
            alu_op_e            op;
            logic [HALF_W-1:0]  a;
            logic [HALF_W-1:0]  b;
        } pend_t;

        pend_t             pend_q;
        logic [HALF_W-1:0] lo_q;
        alu_op_e           x_op;
        logic [HALF_W-1:0] xa, xb, xy;

        // first cycle: low half from the port; second: stored high half
        always_comb begin
            if (phase_hi) begin
                x_op = pend_q.op;
                xa   = pend_q.a;
                xb   = pend_q.b;
            end else begin
                x_op = alu_op_e'(in_op);
                xa   = in_a[HALF_W-1:0];
                xb   = in_b[HALF_W-1:0];
            end
        end

        vsa_exec #(.W(HALF_W)) u_exec (
            .op (x_op),
            .a  (xa),
            .b  (xb),
            .y  (xy)
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                pend_q <= '0;
                lo_q   <= '0;
            end else if (accept) begin
                lo_q     <= xy;
                pend_q.op <= alu_op_e'(in_op);
                pend_q.a  <= in_a[VEC_W-1:HALF_W];
                pend_q.b  <= in_b[VEC_W-1:HALF_W];
            end
        end

        assign res_next = {xy, lo_q};
    end

    always_ff @(posedge clk) begin
        if (rst)           out_q <= '0;
        else if (load_out) out_q <= res_next;
    end

    assign out_data = out_q;

endmodule

// File: rtl/vsa_chk.sv
`timescale 1ns/1ps
module vsa_chk #(
    parameter bit FULL_WIDTH = 1'b0,
    parameter int VEC_W      = 128
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [VEC_W-1:0] out_data
);
    logic half_mode;
    assign half_mode = !FULL_WIDTH;

    // R10
    reset_clears_chk: assert property (@(posedge clk) rst |=> !out_valid);

    // R6
    half_not_early_chk: assert property (@(posedge clk) disable iff (rst)
        (half_mode && in_valid && in_ready) |=> !out_valid);

    // R6
    half_two_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (half_mode && in_valid && in_ready) |-> ##2 out_valid);

    // R7
    half_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (half_mode && in_valid && in_ready) |=> !in_ready);

    // R8
    full_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (!half_mode && in_valid && in_ready) |=> out_valid);

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R9
    stall_block_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

endmodule

bind vec_seq_alu vsa_chk #(.FULL_WIDTH(FULL_WIDTH), .VEC_W(VEC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/vec_seq_alu_test.sv
`timescale 1ns/1ps
module vec_seq_alu_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // half-width instance signals
    logic         h_in_valid = 0, h_in_ready, h_out_valid, h_out_ready = 1;
    logic [2:0]   h_in_op = 0;
    logic [127:0] h_in_a = 0, h_in_b = 0, h_out_data;
    // full-width instance signals
    logic         f_in_valid = 0, f_in_ready, f_out_valid, f_out_ready = 1;
    logic [2:0]   f_in_op = 0;
    logic [127:0] f_in_a = 0, f_in_b = 0, f_out_data;

    vec_seq_alu #(.FULL_WIDTH(1'b0)) uut (
        .clk(clk), .rst(rst), .in_valid(h_in_valid), .in_ready(h_in_ready),
        .in_op(h_in_op), .in_a(h_in_a), .in_b(h_in_b),
        .out_valid(h_out_valid), .out_ready(h_out_ready), .out_data(h_out_data));

    vec_seq_alu #(.FULL_WIDTH(1'b1)) uut_fw (
        .clk(clk), .rst(rst), .in_valid(f_in_valid), .in_ready(f_in_ready),
        .in_op(f_in_op), .in_a(f_in_a), .in_b(f_in_b),
        .out_valid(f_out_valid), .out_ready(f_out_ready), .out_data(f_out_data));

    logic [127:0] hq_exp[$], fq_exp[$];
    int           hq_acc[$], fq_acc[$];
    string        hq_req[$], fq_req[$];
    int           acc_last = 0;

    task automatic check_vec(string req, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_int(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic string op_req(logic [2:0] op);
        case (op)
            3'd0:       return "R1";
            3'd1:       return "R2";
            3'd2, 3'd3: return "R3";
            3'd7:       return "R11";
            default:    return "R4";
        endcase
    endfunction

    // per-lane reference model
    function automatic logic [127:0] ref_op(logic [2:0] op, logic [127:0] a, logic [127:0] b);
        logic [127:0] r = '0;
        case (op)
            3'd0: for (int i = 0; i < 4; i++) r[i*32 +: 32] = a[i*32 +: 32] + b[i*32 +: 32];
            3'd1: for (int i = 0; i < 4; i++) r[i*32 +: 32] = a[i*32 +: 32] - b[i*32 +: 32];
            3'd2: for (int i = 0; i < 2; i++) r[i*64 +: 64] = a[i*64 +: 64] + b[i*64 +: 64];
            3'd3: for (int i = 0; i < 2; i++) r[i*64 +: 64] = a[i*64 +: 64] - b[i*64 +: 64];
            3'd4: r = a & b;
            3'd5: r = a | b;
            3'd6: r = a ^ b;
            default: r = '0;
        endcase
        return r;
    endfunction

    // driver: called just after a falling edge, returns just after a falling edge
    task automatic send(bit fw, logic [2:0] op, logic [127:0] a, logic [127:0] b, string req);
        string tag = (req == "") ? op_req(op) : req;
        if (fw) begin
            f_in_valid = 1; f_in_op = op; f_in_a = a; f_in_b = b;
            while (!f_in_ready) begin @(negedge clk); #1; end
            fq_exp.push_back(ref_op(op, a, b)); fq_acc.push_back(cyc); fq_req.push_back(tag);
            acc_last = cyc;
            @(negedge clk); #1;
        end else begin
            h_in_valid = 1; h_in_op = op; h_in_a = a; h_in_b = b;
            while (!h_in_ready) begin @(negedge clk); #1; end
            hq_exp.push_back(ref_op(op, a, b)); hq_acc.push_back(cyc); hq_req.push_back(tag);
            acc_last = cyc;
            @(negedge clk); #1;
            // R7: no acceptance while the high half runs
            check_int("R7 in_ready after accept", int'(h_in_ready), 0);
        end
    endtask

    task automatic idle();
        h_in_valid = 0;
        f_in_valid = 0;
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    // scoreboard monitors
    bit h_seen = 0, f_seen = 0;
    always begin
        @(negedge clk); #2;
        if (!rst && h_out_valid && !h_seen) begin
            h_seen = 1;
            if (hq_acc.size() > 0) check_int("R6 latency", cyc - hq_acc[0], 2);
        end
        if (!rst && h_out_valid && h_out_ready) begin
            if (hq_exp.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R6 unexpected result actual=%h expected=none", h_out_data);
            end else begin
                check_vec({hq_req.pop_front(), " half"}, h_out_data, hq_exp.pop_front());
                void'(hq_acc.pop_front());
            end
            h_seen = 0;
        end
    end

    always begin
        @(negedge clk); #2;
        if (!rst && f_out_valid && !f_seen) begin
            f_seen = 1;
            if (fq_acc.size() > 0) check_int("R8 latency", cyc - fq_acc[0], 1);
        end
        if (!rst && f_out_valid && f_out_ready) begin
            if (fq_exp.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R8 unexpected result actual=%h expected=none", f_out_data);
            end else begin
                check_vec({fq_req.pop_front(), " full"}, f_out_data, fq_exp.pop_front());
                void'(fq_acc.pop_front());
            end
            f_seen = 0;
        end
    end

    task automatic run_mode(bit fw);
        int t0;
        logic [127:0] ones = '1;
        // directed per-opcode patterns
        send(fw, 3'd0, 128'h7fffffff_00000001_fffffffe_12345678, 128'h00000001_ffffffff_00000003_11111111, "");
        send(fw, 3'd1, 128'h00000000_80000000_00000005_ffffffff, 128'h00000001_00000001_00000007_fffffffe, "");
        send(fw, 3'd2, 128'hffffffff_ffffffff_00000001_00000000, 128'h00000000_00000001_ffffffff_ffffffff, "");
        send(fw, 3'd3, 128'h0, 128'h00000000_00000001_00000000_00000002, "");
        send(fw, 3'd4, 128'hf0f0f0f0_ffff0000_12345678_aaaaaaaa, 128'h0ff00ff0_00ffff00_ffffffff_55555555, "");
        send(fw, 3'd5, 128'hf0f0f0f0_ffff0000_12345678_aaaaaaaa, 128'h0ff00ff0_00ffff00_00000000_55555555, "");
        send(fw, 3'd6, 128'hf0f0f0f0_ffff0000_12345678_aaaaaaaa, 128'h0ff00ff0_00ffff00_ffffffff_55555555, "");
        send(fw, 3'd7, ones, ones, "R11");
        idle();
        // R5: lane boundary carries and borrows
        send(fw, 3'd0, ones, 128'h00000001_00000001_00000001_00000001, "R5");
        send(fw, 3'd2, ones, 128'h00000000_00000001_00000000_00000001, "R5");
        send(fw, 3'd1, 128'h0, 128'h00000001_00000001_00000001_00000001, "R5");
        send(fw, 3'd3, 128'h0, 128'h00000000_00000001_00000000_00000001, "R5");
        send(fw, 3'd0, 128'h80000000_80000000_80000000_80000000, 128'h80000000_80000000_80000000_80000000, "R5");
        idle();
        repeat (4) @(negedge clk);
        #1;
        // back-to-back stream spacing
        send(fw, 3'd0, rnd128(), rnd128(), "");
        t0 = acc_last;
        for (int i = 0; i < 7; i++) send(fw, 3'($urandom_range(0, 7)), rnd128(), rnd128(), "");
        if (fw) check_int("R8 spacing over 8 ops", acc_last - t0, 7);
        else    check_int("R7 spacing over 8 ops", acc_last - t0, 14);
        idle();
        // random operands across all opcodes
        for (int i = 0; i < 40; i++) send(fw, 3'($urandom_range(0, 7)), rnd128(), rnd128(), "");
        idle();
        repeat (4) @(negedge clk);
        #1;
    endtask

    task automatic stall_test(bit fw);
        logic [127:0] held;
        if (fw) f_out_ready = 0; else h_out_ready = 0;
        send(fw, 3'd2, rnd128(), rnd128(), "");
        idle();
        while (!(fw ? f_out_valid : h_out_valid)) begin @(negedge clk); #1; end
        held = fw ? f_out_data : h_out_data;
        // another operation waits at the input during the stall
        if (fw) begin f_in_valid = 1; f_in_op = 3'd6; f_in_a = rnd128(); end
        else    begin h_in_valid = 1; h_in_op = 3'd6; h_in_a = rnd128(); end
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); #1;
            check_int("R9 in_ready during stall", int'(fw ? f_in_ready : h_in_ready), 0);
            check_vec("R9 data held during stall", fw ? f_out_data : h_out_data, held);
            check_int("R9 valid held during stall", int'(fw ? f_out_valid : h_out_valid), 1);
        end
        idle();
        if (fw) f_out_ready = 1; else h_out_ready = 1;
        repeat (4) @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R10: reset values while reset is held
        check_int("R10 half in_ready in reset", int'(h_in_ready), 1);
        check_int("R10 half out_valid in reset", int'(h_out_valid), 0);
        rst = 0;
        @(negedge clk); #1;
        check_int("R10 half out_valid after reset", int'(h_out_valid), 0);
        check_int("R10 full in_ready after reset", int'(f_in_ready), 1);
        check_int("R10 full out_valid after reset", int'(f_out_valid), 0);

        run_mode(1'b0);
        stall_test(1'b0);
        run_mode(1'b1);
        stall_test(1'b1);

        repeat (6) @(negedge clk);
        check_int("R6 half queue drained", hq_exp.size(), 0);
        check_int("R8 full queue drained", fq_exp.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule